// File: doc/BRIEF.md
# Camera Sensor Capture Interface

This block accepts pixel bytes from an image sensor on an 8-bit parallel port and stores them, packed into 32-bit words, in a 32-entry FIFO. The bytes are not interpreted, so YCC, YUV, Bayer and RGB streams all pass through unchanged. Frame and line framing comes from one of two sources. In the first, the sensor drives separate vertical and horizontal sync lines. In the second, the timing is carried inside the data as BT.656-style reference codes. In that case the field, blanking and start/end-of-line flags are decoded from the code word. This covers progressive streams and interlaced PAL/NTSC streams.

The host drains the FIFO through a show-ahead read port. A DMA engine can use the same port when the burst request output asks for service. Four event sources set sticky status bits: frame start, frame end, field change and FIFO full. Each bit is cleared by writing 1 to it, and the bits are combined through a mask into one interrupt line. The block also sends a master clock to the sensor, divided down from the system clock.

Top module: `cam_capture`

## Requirements
- R1: With `pack16_i` low, four consecutive captured bytes b0..b3 form the word {b3,b2,b1,b0}, so the first byte lands in bits [7:0].
- R2: With `pack16_i` high, each 16-bit sample arrives high byte first and the first sample sits in the low half, so bytes b0..b3 form the word {b2,b3,b0,b1}.
- R3: At frame end, a word that holds fewer than four bytes is discarded and does not reach the FIFO. Packing of the next frame starts from an empty word.
- R4: In discrete-sync mode (`embed_sync_i` low), a byte is captured only when `pix_vld_i`, `vsync_i` and `hsync_i` are all high. The rising edge of `vsync_i` raises frame start (status bit 0) and the falling edge raises frame end (status bit 1).
- R5: In embedded mode, a reference code is FF 00 00 XY. In XY, bit 6 is the field flag F, bit 5 is the blanking flag V and bit 4 is H (0 = start of active line, 1 = end of active line). Bytes are captured only between a start code with V=0 and the next end code. The code bytes themselves and bytes on blanking lines (V=1) are never captured.
- R6: In embedded mode, V falling from 1 to 0 raises frame start (bit 0). V rising from 0 to 1 raises frame end (bit 1). A code whose F differs from the previous code's F raises field change (bit 2). After reset, V is taken as 1 and F as 0.
- R7: The FIFO is 32 words deep and presents its oldest word on `rd_data_o`. A cycle with `rd_en_i` high removes that word. `fifo_level_o` gives the number of stored words and reads 0 after reset.
- R8: A word arriving while the FIFO holds 32 words is dropped and sets the sticky `ovf_o`, which `ovf_clr_i` clears. The level reaching 32 raises FIFO-full (bit 3).
- R9: `dma_req_o` is high exactly when `burst_thr_i` is non-zero and `fifo_level_o` is at least `burst_thr_i`.
- R10: Status bits reset to 0, stay set until a 1 is written on the matching `irq_clr_i` bit, and `irq_o` is the OR of `irq_status_o & irq_mask_i`.
- R11: `mclk_o` resets low and has a period of 2×(N+1) system clocks with N+1 high cycles, where N is `mclk_div_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| embed_sync_i | input | 1 | 1 = embedded reference codes, 0 = discrete sync lines |
| pack16_i | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| pix_data_i | input | 8 | Pixel byte from the sensor |
| pix_vld_i | input | 1 | Pixel byte strobe |
| vsync_i | input | 1 | Vertical sync, active high |
| hsync_i | input | 1 | Horizontal sync / line valid, active high |
| rd_en_i | input | 1 | Remove the word shown on rd_data_o |
| rd_data_o | output | 32 | Oldest FIFO word |
| fifo_level_o | output | 6 | Words held in the FIFO |
| burst_thr_i | input | 6 | Level at which a DMA burst is requested (0 disables) |
| dma_req_o | output | 1 | DMA burst request |
| irq_mask_i | input | 4 | Interrupt enable per status bit |
| irq_clr_i | input | 4 | Write-1-to-clear per status bit |
| irq_status_o | output | 4 | Sticky events: 0 frame start, 1 frame end, 2 field change, 3 FIFO full |
| irq_o | output | 1 | Combined masked interrupt |
| ovf_o | output | 1 | Sticky FIFO overflow |
| ovf_clr_i | input | 1 | Clears ovf_o |
| mclk_div_i | input | 4 | Master clock divider N |
| mclk_o | output | 1 | Master clock to the sensor |

## Verification
The packing path is swept over both sync modes, both sample widths and every frame length from 0 to 13 bytes, so all four remainder cases of the byte-to-word count are hit in each combination. Comparing word contents separates the two lane orders. Comparing levels separates correct partial-word discard from leaked bytes. In discrete-sync mode, a byte is strobed while the line signal is low. In embedded mode, blanking lines with data and split active lines are sent, and a wrong level exposes capture outside the active window. Alternating field flags across embedded frames separates field-change events from frame events. A 41-word frame into an undrained FIFO shows the drop-on-full rule, and a sweep of all 16 divider values pins down the clock period and duty cycle.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
  localparam int unsigned NUM_EV  = 4;
  localparam int unsigned EV_SOF  = 0;
  localparam int unsigned EV_EOF  = 1;
  localparam int unsigned EV_FLD  = 2;
  localparam int unsigned EV_FULL = 3;
  localparam logic [7:0] SYNC_FF  = 8'hFF;
  localparam logic [7:0] SYNC_00  = 8'h00;
endpackage

// File: rtl/cam_sync_decode.sv
module cam_sync_decode import cam_cap_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       embed_i,
  input  logic       pix_vld_i,
  input  logic [7:0] pix_i,
  input  logic       vsync_i,
  input  logic       hsync_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       sof_o,
  output logic       eof_o,
  output logic       fld_o
);
  // pre_q: 0 none, 1 after FF, 2 after FF 00, 3 after FF 00 00 (next byte is XY)
  logic [1:0] pre_q, pre_d;
  logic       v_q, f_q, line_q, vs_q;
  logic       is_code, emb_data;
  logic       xy_f, xy_v, xy_h;

  assign xy_f     = pix_i[6];
  assign xy_v     = pix_i[5];
  assign xy_h     = pix_i[4];
  assign is_code  = pix_vld_i && (pre_q == 2'd3);
  assign emb_data = pix_vld_i && line_q && (pre_q == 2'd0) && (pix_i != SYNC_FF);

  always_comb begin
    pre_d = 2'd0;
    if (pre_q == 2'd3)                         pre_d = 2'd0;
    else if (pix_i == SYNC_FF)                 pre_d = 2'd1;
    else if (pre_q == 2'd1 && pix_i == SYNC_00) pre_d = 2'd2;
    else if (pre_q == 2'd2 && pix_i == SYNC_00) pre_d = 2'd3;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= 2'd0;
      v_q        <= 1'b1;
      f_q        <= 1'b0;
      line_q     <= 1'b0;
      vs_q       <= 1'b0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      fld_o      <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      sof_o      <= 1'b0;
      eof_o      <= 1'b0;
      fld_o      <= 1'b0;
      vs_q       <= vsync_i;
      if (pix_vld_i) byte_o <= pix_i;
      if (embed_i) begin
        if (pix_vld_i) begin
          pre_q      <= pre_d;
          byte_vld_o <= emb_data;
          if (is_code) begin
            v_q    <= xy_v;
            f_q    <= xy_f;
            line_q <= ~xy_h & ~xy_v;
            sof_o  <= v_q & ~xy_v;
            eof_o  <= ~v_q & xy_v;
            fld_o  <= f_q ^ xy_f;
          end
        end
      end else begin
        pre_q      <= 2'd0;
        line_q     <= 1'b0;
        byte_vld_o <= pix_vld_i & vsync_i & hsync_i;
        sof_o      <= vsync_i & ~vs_q;
        eof_o      <= ~vsync_i & vs_q;
      end
    end
  end

  // R6
  sof_eof_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> !eof_o);
  // R5
  code_not_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (embed_i && is_code) |=> !byte_vld_o);
endmodule

// File: rtl/cam_packer.sv
module cam_packer #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES  = WORD_W / 8,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pack16_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  logic [LANE_W-1:0] cnt_q, lane;
  logic [WORD_W-1:0] acc_q, acc_d;
  logic              last;

  // 16-bit samples: high byte first, so swap the byte pair inside each sample
  assign lane = pack16_i ? (cnt_q ^ LANE_W'(1)) : cnt_q;
  assign last = (cnt_q == LANE_W'(LANES - 1));

  always_comb begin
    acc_d = acc_q;
    acc_d[{lane, 3'b000} +: 8] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (flush_i) begin
        cnt_q <= '0;
      end else if (byte_vld_i) begin
        acc_q <= acc_d;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
        if (last) begin
          word_o     <= acc_d;
          word_vld_o <= 1'b1;
        end
      end
    end
  end

  // R3
  flush_no_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !word_vld_o);
endmodule

// File: rtl/cam_fifo.sv
module cam_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             ovf_o,
  input  logic             ovf_clr_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] lvl_q;
  logic             do_push, do_pop;

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && (lvl_q != '0);
  assign rdata_o = mem_q[rd_q];
  assign level_o = lvl_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
      if (push_i && full_o) ovf_o <= 1'b1;
      else if (ovf_clr_i)   ovf_o <= 1'b0;
    end
  end

  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  // R8
  drop_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> ovf_o);
  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q == '0 && !push_i) |=> (lvl_q == '0));
endmodule

// File: rtl/cam_mclk_gen.sv
module cam_mclk_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mclk_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mclk_o <= 1'b0;
    end else if (cnt_q >= div_i) begin
      cnt_q  <= '0;
      mclk_o <= ~mclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R11
  mclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < div_i) |=> $stable(mclk_o));
endmodule

// File: rtl/cam_capture.sv
module cam_capture import cam_cap_pkg::*; #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned DIV_W      = 4,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              embed_sync_i,
  input  logic              pack16_i,
  input  logic [7:0]        pix_data_i,
  input  logic              pix_vld_i,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  fifo_level_o,
  input  logic [CNT_W-1:0]  burst_thr_i,
  output logic              dma_req_o,
  input  logic [NUM_EV-1:0] irq_mask_i,
  input  logic [NUM_EV-1:0] irq_clr_i,
  output logic [NUM_EV-1:0] irq_status_o,
  output logic              irq_o,
  output logic              ovf_o,
  input  logic              ovf_clr_i,
  input  logic [DIV_W-1:0]  mclk_div_i,
  output logic              mclk_o
);
  logic [7:0]        dec_byte;
  logic              dec_vld, ev_sof, ev_eof, ev_fld;
  logic [WORD_W-1:0] pk_word;
  logic              pk_vld;
  logic              fifo_full, full_q;
  logic [NUM_EV-1:0] ev, st_q;

  cam_sync_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .embed_i    (embed_sync_i),
    .pix_vld_i  (pix_vld_i),
    .pix_i      (pix_data_i),
    .vsync_i    (vsync_i),
    .hsync_i    (hsync_i),
    .byte_o     (dec_byte),
    .byte_vld_o (dec_vld),
    .sof_o      (ev_sof),
    .eof_o      (ev_eof),
    .fld_o      (ev_fld)
  );

  cam_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pack16_i   (pack16_i),
    .byte_i     (dec_byte),
    .byte_vld_i (dec_vld),
    .flush_i    (ev_eof),
    .word_o     (pk_word),
    .word_vld_o (pk_vld)
  );

  cam_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (pk_vld),
    .wdata_i   (pk_word),
    .pop_i     (rd_en_i),
    .rdata_o   (rd_data_o),
    .level_o   (fifo_level_o),
    .full_o    (fifo_full),
    .ovf_o     (ovf_o),
    .ovf_clr_i (ovf_clr_i)
  );

  cam_mclk_gen #(.DIV_W(DIV_W)) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (mclk_div_i),
    .mclk_o (mclk_o)
  );

  always_comb begin
    ev          = '0;
    ev[EV_SOF]  = ev_sof;
    ev[EV_EOF]  = ev_eof;
    ev[EV_FLD]  = ev_fld;
    ev[EV_FULL] = fifo_full & ~full_q;
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      st_q   <= '0;
    end else begin
      full_q <= fifo_full;
      st_q   <= (st_q & ~irq_clr_i) | ev;
    end
  end

  assign irq_status_o = st_q;
  assign irq_o        = |(st_q & irq_mask_i);
  assign dma_req_o    = (burst_thr_i != '0) && (fifo_level_o >= burst_thr_i);

  // R10
  sof_sets_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_sof |=> irq_status_o[EV_SOF]);
  // R10
  status_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o[EV_EOF] && !irq_clr_i[EV_EOF]) |=> irq_status_o[EV_EOF]);
  // R9
  empty_no_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_level_o == '0) |-> !dma_req_o);
endmodule

// File: tb/cam_capture_test.sv
module cam_capture_test;
  localparam int DEPTH = 32;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] pix = '0;
  logic pv = 1'b0, vs = 1'b0, hs = 1'b0, emb = 1'b0, p16 = 1'b0;
  logic rd = 1'b0, ovf_clr = 1'b0;
  logic [3:0] div = '0, mask = '0, clr = '0;
  logic [CNT_W-1:0] thr = CNT_W'(2);
  logic [31:0] rdata;
  logic [CNT_W-1:0] lvl;
  logic dma, irq, ovf, mclk;
  logic [3:0] st;

  int checks = 0, fails = 0;
  logic [7:0] fb[$];
  bit last_f = 1'b0;

  always #4 clk = ~clk;

  cam_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .embed_sync_i(emb), .pack16_i(p16),
    .pix_data_i(pix), .pix_vld_i(pv), .vsync_i(vs), .hsync_i(hs),
    .rd_en_i(rd), .rd_data_o(rdata), .fifo_level_o(lvl), .burst_thr_i(thr),
    .dma_req_o(dma), .irq_mask_i(mask), .irq_clr_i(clr), .irq_status_o(st),
    .irq_o(irq), .ovf_o(ovf), .ovf_clr_i(ovf_clr), .mclk_div_i(div), .mclk_o(mclk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input int seed, input int k);
    return 8'(((seed * 13 + k * 37) % 254) + 1);
  endfunction

  function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic put(input logic [7:0] b, input logic v_s, input logic h_s, input logic valid);
    @(negedge clk);
    pix = b; vs = v_s; hs = h_s; pv = valid;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      pv = 1'b0;
    end
  endtask

  task automatic code(input bit f, input bit v, input bit h);
    put(8'hFF, 0, 0, 1); put(8'h00, 0, 0, 1); put(8'h00, 0, 0, 1); put(xy(f, v, h), 0, 0, 1);
  endtask

  task automatic conv_frame(input int seed, input int n);
    fb.delete();
    put(8'h00, 1, 0, 0); put(8'h00, 1, 0, 0);
    put(8'h5A, 1, 0, 1);                 // R4: strobe with line low, ignored
    for (int k = 0; k < n; k++) begin
      if (k == n / 2) begin put(8'hA5, 1, 0, 1); put(8'h00, 1, 0, 0); end
      put(byte_at(seed, k), 1, 1, 1);
      fb.push_back(byte_at(seed, k));
    end
    put(8'h00, 1, 0, 0); put(8'h00, 0, 0, 0);
    idle(6);
  endtask

  task automatic emb_frame(input int seed, input int n, input bit f);
    fb.delete();
    code(f, 1, 0);                       // R5: blanking line with data, ignored
    for (int k = 0; k < 3; k++) put(byte_at(seed + 99, k), 0, 0, 1);
    code(f, 1, 1);
    code(f, 0, 0);
    for (int k = 0; k < n; k++) begin
      if (k == n / 2) begin code(f, 0, 1); code(f, 0, 0); end
      put(byte_at(seed, k), 0, 0, 1);
      fb.push_back(byte_at(seed, k));
    end
    code(f, 0, 1);
    code(f, 1, 1);
    idle(6);
  endtask

  task automatic drain(input int nw, input bit wide);
    for (int w = 0; w < nw; w++) begin
      logic [31:0] e;
      e = wide ? {fb[4*w+2], fb[4*w+3], fb[4*w], fb[4*w+1]}
               : {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]};
      chk(wide ? "R2" : "R1", rdata, e);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
    end
    chk("R7", 32'(lvl), 32'd0);
  endtask

  task automatic clear_status();
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = 4'h0;
    chk("R10", 32'(st), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int idx = 0;
    repeat (2) @(negedge clk);
    chk("R11", 32'(mclk), 32'd0);
    chk("R7", 32'(lvl), 32'd0);
    chk("R10", {27'd0, irq, st}, 32'd0);
    chk("R9", 32'(dma), 32'd0);
    rst_n = 1'b1;
    idle(2);

    for (int m = 0; m < 2; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int n = 0; n < 14; n++) begin
          bit f, fexp;
          logic [3:0] exp_st;
          int nw;
          emb = m[0]; p16 = w[0];
          mask = 4'((idx * 5) % 16);
          f = n[0];
          fexp = 1'b0;
          if (m == 1) begin
            fexp = (f != last_f);
            last_f = f;
            emb_frame(idx, n, f);
          end else begin
            conv_frame(idx, n);
          end
          nw = n / 4;
          if (n % 4 != 0) chk("R3", 32'(lvl), 32'(nw));
          else            chk(m == 1 ? "R5" : "R4", 32'(lvl), 32'(nw));
          chk("R9", 32'(dma), 32'(nw >= 2));
          exp_st = {1'b0, fexp, 1'b1, 1'b1};
          chk(m == 1 ? "R6" : "R4", 32'(st), 32'(exp_st));
          chk("R10", 32'(irq), 32'(|(exp_st & mask)));
          clear_status();
          drain(nw, w[0]);
          idx++;
        end
      end
    end

    // R8: overflow with 41 words into an undrained FIFO
    emb = 1'b0; p16 = 1'b0;
    conv_frame(500, 164);
    chk("R8", 32'(lvl), 32'd32);
    chk("R8", 32'(ovf), 32'd1);
    chk("R8", 32'(st[3]), 32'd1);
    chk("R9", 32'(dma), 32'd1);
    drain(32, 1'b0);
    chk("R8", 32'(ovf), 32'd1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8", 32'(ovf), 32'd0);
    clear_status();

    // R11: divider sweep
    for (int nd = 0; nd < 16; nd++) begin
      int per, hi;
      logic prev;
      div = 4'(nd);
      idle(40);
      prev = mclk;
      @(negedge clk);
      while (!(mclk === 1'b1 && prev === 1'b0)) begin
        prev = mclk;
        @(negedge clk);
      end
      per = 0; hi = 0;
      do begin
        if (mclk) hi++;
        per++;
        prev = mclk;
        @(negedge clk);
      end while (!(mclk === 1'b1 && prev === 1'b0));
      chk("R11", 32'(per), 32'(2 * (nd + 1)));
      chk("R11", 32'(hi), 32'(nd + 1));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule